// File: doc/BRIEF.md
# Program Memory Table Read Unit

This block carries out table lookups from program memory for a small 8-bit microcontroller core. A table word address is 10 bits wide: the low 8 bits come from a software-visible pointer register, and the upper two bits select a page of program memory. The page is either the page the program counter is currently executing in, or the final page of program memory, depending on which form of the instruction the decoder issued.

When the decoder raises the instruction strobe, the unit presents the address to a synchronous program ROM in that same cycle. In the following cycle it commits the result. The fetched 14-bit word is split in two. Its low byte goes out on a data-memory write port, to the location that the instruction named. Its upper six bits land in a read-only high-byte register, whose two top bits always read as zero. Software reaches the pointer register and the high-byte register through a simple register-bus port.

Top module: `tblrd_unit`

## Requirements
- R1: A synchronous active-high reset clears the pointer register and the high-byte register to zero, and leaves `busy`, `done`, `dst_we` and `rom_en` low.
- R2: A register-bus write to address 0x07 loads the pointer register at the clock edge. A read of 0x07 returns the pointer's value.
- R3: The high-byte register at address 0x08 is read-only. Bus writes to 0x08 leave its value unchanged, and bits 7:6 of a read at 0x08 are always 0.
- R4: A bus read of any address other than 0x07 or 0x08 returns 0.
- R5: With `ins_last_page` = 0, the issue cycle drives `rom_addr` = {`pc_page`, pointer} and raises `rom_en`.
- R6: With `ins_last_page` = 1, the issue cycle drives `rom_addr` = {2'b11, pointer} and raises `rom_en`.
- R7: In the commit cycle, `dst_we` is 1, `dst_addr` equals the `ins_dest` value captured in the issue cycle, and `dst_data` equals bits 7:0 of `rom_data`.
- R8: At the end of the commit cycle, the high-byte register takes bits 13:8 of `rom_data`. Reads at 0x08 show the new value from the next cycle onward.
- R9: A table read takes exactly two cycles. `busy` is high in the issue cycle (`ins_go` accepted while idle), and `done` is high in the cycle that follows. An `ins_go` that arrives during the commit cycle is ignored.
- R10: A pointer write in the same cycle as an issue does not change that read's address. It only takes effect for later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register-bus address |
| bus_wr | input | 1 | Register-bus write enable |
| bus_wdata | input | 8 | Register-bus write data |
| bus_rdata | output | 8 | Register-bus read data (combinational) |
| ins_go | input | 1 | Table-read instruction strobe |
| ins_last_page | input | 1 | 1 = final page, 0 = current program-counter page |
| ins_dest | input | 7 | Data-memory destination address for the low byte |
| pc_page | input | 2 | Program counter bits 9:8 |
| rom_en | output | 1 | Program ROM read enable |
| rom_addr | output | 10 | Program ROM word address |
| rom_data | input | 14 | Program ROM data, valid the cycle after `rom_en` |
| dst_we | output | 1 | Data-memory write enable |
| dst_addr | output | 7 | Data-memory write address |
| dst_data | output | 8 | Data-memory write data |
| busy | output | 1 | High in the issue cycle |
| done | output | 1 | High in the commit cycle |

## Verification
The hardest case to reach from the ports is a pointer write that lands in the same cycle as an instruction issue. The address must then use the old pointer, while the next read uses the new one. A second hard case is a strobe that arrives during the commit cycle, which must be dropped. The bench drives `ins_go` with a high probability and mixes in frequent bus writes to 0x07 and 0x08, so both collisions come up many times. Directed sequences then force each collision explicitly. A behavioural model predicts every output on every cycle.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
    parameter int PTR_W    = 8;
    parameter int PAGE_W   = 2;
    parameter int WORD_W   = 14;
    parameter int DATA_W   = 8;
    parameter int DMEM_AW  = 7;
    parameter int RADDR_W  = 8;

    localparam int TADDR_W = PTR_W + PAGE_W;
    localparam int HI_W    = WORD_W - DATA_W;
    localparam int PAD_W   = DATA_W - HI_W;

    localparam logic [RADDR_W-1:0] PTR_REG_ADDR = RADDR_W'(8'h07);
    localparam logic [RADDR_W-1:0] HI_REG_ADDR  = RADDR_W'(8'h08);
    localparam logic [PAGE_W-1:0]  LAST_PAGE    = '1;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_COMMIT = 1'b1
    } phase_e;

    typedef enum logic {
        PG_CURRENT = 1'b0,
        PG_LAST    = 1'b1
    } page_sel_e;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] lo;
    } pword_t;

    function automatic pword_t split_word(input logic [WORD_W-1:0] w);
        pword_t r;
        r = pword_t'(w);
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] widen_hi(input logic [HI_W-1:0] h);
        return {{PAD_W{1'b0}}, h};
    endfunction
endpackage

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen
    import tblrd_pkg::*;
(
    input  logic [PTR_W-1:0]   ptr,
    input  logic [PAGE_W-1:0]  pc_page,
    input  page_sel_e          sel,
    output logic [TADDR_W-1:0] taddr
);
    logic [PAGE_W-1:0] page;

    generate
        if (PAGE_W > 0) begin : g_paged
            always_comb begin
                page = (sel == PG_LAST) ? LAST_PAGE : pc_page;
            end
        end else begin : g_flat
            always_comb page = '0;
        end
    endgenerate

    assign taddr = {page, ptr};
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq
    import tblrd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [DMEM_AW-1:0] dest_in,
    output logic               issue,
    output logic               commit,
    output logic [DMEM_AW-1:0] dest_q
);
    phase_e phase_q;

    assign issue  = (phase_q == PH_IDLE) && go;
    assign commit = (phase_q == PH_COMMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            dest_q  <= '0;
        end else begin
            phase_q <= issue ? PH_COMMIT : PH_IDLE;
            if (issue) dest_q <= dest_in;
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(issue && commit)); // R9
    AST_ISSUE_THEN_COMMIT: assert property (@(posedge clk) disable iff (rst)
        issue |=> commit); // R9
    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit); // R9
endmodule

// File: rtl/tblrd_regs.sv
module tblrd_regs
    import tblrd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RADDR_W-1:0] bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               commit,
    input  logic [HI_W-1:0]    hi_in,
    output logic [PTR_W-1:0]   ptr_q,
    output logic [DATA_W-1:0]  bus_rdata
);
    logic [HI_W-1:0] hi_q;
    logic            ptr_wr;

    assign ptr_wr = bus_wr && (bus_addr == PTR_REG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            hi_q  <= '0;
        end else begin
            if (ptr_wr) ptr_q <= bus_wdata[PTR_W-1:0];
            if (commit) hi_q  <= hi_in;
        end
    end

    always_comb begin
        unique case (bus_addr)
            PTR_REG_ADDR: bus_rdata = DATA_W'(ptr_q);
            HI_REG_ADDR:  bus_rdata = widen_hi(hi_q);
            default:      bus_rdata = '0;
        endcase
    end

    AST_HI_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == HI_REG_ADDR && !commit) |=> $stable(hi_q)); // R3
    AST_HI_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == HI_REG_ADDR) |-> (bus_rdata[DATA_W-1:HI_W] == '0)); // R3
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ptr_wr |=> $stable(ptr_q)); // R2
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
    import tblrd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [RADDR_W-1:0]  bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                ins_go,
    input  logic                ins_last_page,
    input  logic [DMEM_AW-1:0]  ins_dest,
    input  logic [PAGE_W-1:0]   pc_page,
    output logic                rom_en,
    output logic [TADDR_W-1:0]  rom_addr,
    input  logic [WORD_W-1:0]   rom_data,
    output logic                dst_we,
    output logic [DMEM_AW-1:0]  dst_addr,
    output logic [DATA_W-1:0]   dst_data,
    output logic                busy,
    output logic                done
);
    logic             issue;
    logic             commit;
    logic [PTR_W-1:0] ptr;
    pword_t           word;
    page_sel_e        sel;

    assign sel  = ins_last_page ? PG_LAST : PG_CURRENT;
    assign word = split_word(rom_data);

    tblrd_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .go      (ins_go),
        .dest_in (ins_dest),
        .issue   (issue),
        .commit  (commit),
        .dest_q  (dst_addr)
    );

    tblrd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .commit    (commit),
        .hi_in     (word.hi),
        .ptr_q     (ptr),
        .bus_rdata (bus_rdata)
    );

    tblrd_addr_gen u_addr (
        .ptr     (ptr),
        .pc_page (pc_page),
        .sel     (sel),
        .taddr   (rom_addr)
    );

    assign rom_en   = issue;
    assign busy     = issue;
    assign done     = commit;
    assign dst_we   = commit;
    assign dst_data = word.lo;

    AST_LAST_PAGE: assert property (@(posedge clk) disable iff (rst)
        (rom_en && ins_last_page) |-> (rom_addr[TADDR_W-1:PTR_W] == LAST_PAGE)); // R6
    AST_CUR_PAGE: assert property (@(posedge clk) disable iff (rst)
        (rom_en && !ins_last_page) |-> (rom_addr[TADDR_W-1:PTR_W] == pc_page)); // R5
    AST_DEST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        busy |=> (dst_we && dst_addr == $past(ins_dest))); // R7
endmodule

// File: tb/tblrd_unit_bench.sv
module tblrd_unit_bench;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       ins_go;
    logic       ins_last_page;
    logic [6:0] ins_dest;
    logic [1:0] pc_page;
    logic       rom_en;
    logic [9:0] rom_addr;
    logic [13:0] rom_data;
    logic       dst_we;
    logic [6:0] dst_addr;
    logic [7:0] dst_data;
    logic       busy;
    logic       done;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    tblrd_unit u_tblrd_unit (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ins_go(ins_go), .ins_last_page(ins_last_page), .ins_dest(ins_dest), .pc_page(pc_page),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_data),
        .dst_we(dst_we), .dst_addr(dst_addr), .dst_data(dst_data),
        .busy(busy), .done(done)
    );

    function automatic logic [13:0] rom_fn(input logic [9:0] a);
        return 14'((int'(a) * 613 + 14'h2A5) ^ (int'(a) << 4));
    endfunction

    // synchronous ROM model
    always @(posedge clk) if (rom_en) rom_data <= rom_fn(rom_addr);

    // behavioural reference model
    int   m_ptr, m_hi, m_dest;
    bit   m_commit;
    bit   m_ptr_wr_now;

    always @(posedge clk) begin
        if (rst) begin
            m_ptr = 0; m_hi = 0; m_dest = 0; m_commit = 0;
        end else begin
            bit iss;
            iss = !m_commit && ins_go;
            if (m_commit) m_hi = int'(rom_data) >> 8;
            if (iss) m_dest = int'(ins_dest);
            if (bus_wr && bus_addr == 8'h07) m_ptr = int'(bus_wdata);
            m_commit = iss;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            bit iss;
            int ea, er;
            string rtag;
            iss = !m_commit && ins_go;
            chk(busy == iss, "R9", "busy", int'(busy), int'(iss));
            chk(done == m_commit, "R9", "done", int'(done), int'(m_commit));
            chk(rom_en == iss, ins_last_page ? "R6" : "R5", "rom_en", int'(rom_en), int'(iss));
            if (iss) begin
                ea = ((ins_last_page ? 3 : int'(pc_page)) << 8) | m_ptr;
                chk(int'(rom_addr) == ea,
                    (bus_wr && bus_addr == 8'h07) ? "R10" : (ins_last_page ? "R6" : "R5"),
                    "rom_addr", int'(rom_addr), ea);
            end
            chk(dst_we == m_commit, "R7", "dst_we", int'(dst_we), int'(m_commit));
            if (m_commit) begin
                chk(int'(dst_addr) == m_dest, "R7", "dst_addr", int'(dst_addr), m_dest);
                chk(int'(dst_data) == (int'(rom_data) & 8'hFF), "R7", "dst_data",
                    int'(dst_data), int'(rom_data) & 8'hFF);
            end
            if (bus_addr == 8'h07)      begin er = m_ptr; rtag = "R2"; end
            else if (bus_addr == 8'h08) begin er = m_hi;  rtag = "R8"; end
            else                        begin er = 0;     rtag = "R4"; end
            chk(int'(bus_rdata) == er, rtag, "bus_rdata", int'(bus_rdata), er);
            if (bus_addr == 8'h08)
                chk(bus_rdata[7:6] == 2'b00, "R3", "hi top bits", int'(bus_rdata[7:6]), 0);
        end
    end

    task automatic idle_inputs();
        bus_addr = 8'h00; bus_wr = 0; bus_wdata = 0;
        ins_go = 0; ins_last_page = 0; ins_dest = 0; pc_page = 0;
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic wr_ptr(input logic [7:0] v);
        bus_addr = 8'h07; bus_wr = 1; bus_wdata = v; step(); bus_wr = 0;
    endtask

    // one table read; returns after the commit cycle
    task automatic tread(input bit last, input logic [1:0] pg, input logic [6:0] d);
        ins_go = 1; ins_last_page = last; pc_page = pg; ins_dest = d;
        step(); ins_go = 0; step();
    endtask

    bit finished = 0;

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        chk(!busy && !done && !dst_we && !rom_en, "R1", "ctrl after reset",
            {busy, done, dst_we, rom_en}, 0);
        bus_addr = 8'h07; #1;
        chk(bus_rdata == 0, "R1", "ptr after reset", int'(bus_rdata), 0);
        bus_addr = 8'h08; #1;
        chk(bus_rdata == 0, "R1", "hi after reset", int'(bus_rdata), 0);
        @(negedge clk);
        rst = 0;

        // R2 then R5 current-page read
        wr_ptr(8'h5C);
        tread(0, 2'b01, 7'h21);
        bus_addr = 8'h08; step();
        // R6 last-page read
        wr_ptr(8'hF3);
        tread(1, 2'b00, 7'h40);
        // R3: write to high-byte register is ignored
        bus_addr = 8'h08; bus_wr = 1; bus_wdata = 8'hFF; step(); bus_wr = 0; step();
        // R4: unmapped address
        bus_addr = 8'h09; step(); bus_addr = 8'h06; step();
        // R10: pointer write coinciding with issue
        bus_addr = 8'h07; bus_wr = 1; bus_wdata = 8'h12;
        ins_go = 1; ins_last_page = 0; pc_page = 2'b10; ins_dest = 7'h33;
        step(); bus_wr = 0; ins_go = 0; step();
        tread(0, 2'b10, 7'h34);
        // R9: go held high, commit-cycle strobes ignored
        ins_go = 1; ins_last_page = 1; ins_dest = 7'h5F;
        repeat (6) step();
        ins_go = 0; step();
        // R8: write to hi during commit still takes ROM value
        ins_go = 1; step(); ins_go = 0;
        bus_addr = 8'h08; bus_wr = 1; bus_wdata = 8'hAA; step(); bus_wr = 0; step();

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            bus_addr = (r < 4) ? 8'h07 : (r < 8) ? 8'h08 : 8'($urandom_range(0, 31));
            bus_wr = ($urandom_range(0, 2) == 0);
            bus_wdata = 8'($urandom);
            ins_go = ($urandom_range(0, 3) != 0);
            ins_last_page = 1'($urandom);
            pc_page = 2'($urandom);
            ins_dest = 7'($urandom);
            step();
        end
        idle_inputs();
        repeat (3) step();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule